// File: doc/BRIEF.md
# Statistical Corrector for Branch Direction

This block refines a branch direction prediction that has already been produced upstream. Alongside the upstream direction it receives the signed confidence counter that produced it. It adds that confidence to the votes of several small tables of signed saturating counters. Each table is addressed by the branch address mixed with a different length of global branch history. When the combined vote points the other way and is strong enough, the block flips the upstream direction. Otherwise the upstream direction passes through unchanged. The direction presented here is the effective one, after any upstream choice between a provider and an alternate prediction.

A lookup is a single-cycle request on the prediction port. The final direction and the magnitude of the vote appear one cycle later. When the branch resolves, the resolution port carries the same address, history, upstream direction and confidence counter, plus the real outcome. The block repeats the vote against its current table contents. It trains every addressed counter when the corrected prediction was wrong, or when the vote was too weak to be trusted. A lookup and a resolution in the same cycle do not interact: the lookup sees the counters as they stood before that cycle's training.

Top module: `sc_corrector`

## Requirements
- R1: After reset every counter in every table is zero and pred_valid_o is low.
- R2: pred_valid_o is high in exactly the cycle after a cycle with pred_valid_i high, and pred_taken_o and pred_mag_o belong to that request.
- R3: Table t is addressed by pc[IDX_W+1:2] XOR a fold of history bits [L_t-1:0], where history bit i toggles address bit (i mod IDX_W). The default lengths L are 0, 8, 16 and 32 for tables 0 to 3, and IDX_W is 8. Address bits outside that slice and history bits at or above L_t have no effect on table t.
- R4: The vote is seeded with (2*|p|+1), where p is the two's-complement provider counter. The seed is positive when the upstream direction is taken (1) and negative when it is not taken (0). Each addressed counter c then adds 2*c+1, and pred_mag_o is the absolute value of the total.
- R5: A total of zero or more means taken. pred_taken_o is the inverse of pred_dir_i only when the total's sign disagrees with it and the magnitude is above THRESH (default 20). With a magnitude of THRESH or below, pred_dir_i is kept.
- R6: On upd_valid_i the block recomputes the vote and final direction from the resolution fields against the current counters. If the final direction differs from upd_taken_i, or the magnitude is THRESH or below, every addressed counter moves one step toward the outcome (up for taken). Otherwise no counter changes.
- R7: Counters saturate: a counter at 2^(CTR_W-1)-1 stays there when trained up, and a counter at -2^(CTR_W-1) stays there when trained down.
- R8: Counters change only through R6: resolution fields presented with upd_valid_i low, and any number of lookups, leave every later vote unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_valid_i | input | 1 | Lookup request |
| pred_pc_i | input | 32 | Branch address for lookup |
| pred_ghist_i | input | 64 | Global history for lookup, bit 0 most recent |
| pred_dir_i | input | 1 | Upstream effective direction, 1 = taken |
| pred_ctr_i | input | 3 | Upstream provider counter, two's complement |
| pred_valid_o | output | 1 | Lookup result valid |
| pred_taken_o | output | 1 | Final direction |
| pred_mag_o | output | 11 | Absolute value of the vote |
| upd_valid_i | input | 1 | Resolution request |
| upd_pc_i | input | 32 | Branch address at resolution |
| upd_ghist_i | input | 64 | Global history used at lookup time |
| upd_dir_i | input | 1 | Upstream effective direction used at lookup time |
| upd_ctr_i | input | 3 | Upstream provider counter used at lookup time |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
Counter saturation is the hardest state to reach from the ports. Training stops as soon as the vote is both correct and above the threshold, so the counters normally settle far from their limits. The bench therefore narrows the counters to three bits. It then feeds resolutions whose provider seed opposes the outcome, so the vote stays weak while every counter climbs to its upper limit or sinks to its lower limit. Once the counters sit at a limit, a history pattern that changes only the bits beyond a given table's length separates the tables one at a time. The bench then shows that the overrides flip exactly at the threshold boundary.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned HLEN_W = 8;

  typedef enum logic [1:0] {
    TRAIN_NONE = 2'd0,
    TRAIN_UP   = 2'd1,
    TRAIN_DOWN = 2'd2
  } train_act_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // vote width: widest term, growth for all terms, sign and the 2x+1 shift
  function automatic int unsigned sum_width(int unsigned ctr_w, int unsigned prov_w,
                                            int unsigned n_tbl);
    return max_u(ctr_w, prov_w) + $clog2(n_tbl + 2) + 2;
  endfunction

endpackage

// File: rtl/sc_index_hash.sv
module sc_index_hash #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned GHIST_W = 64,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned HLEN    = 0
) (
  input  logic [PC_W-1:0]    pc_i,
  input  logic [GHIST_W-1:0] ghist_i,
  output logic [IDX_W-1:0]   idx_o
);

  localparam int unsigned USE_LEN = (HLEN > GHIST_W) ? GHIST_W : HLEN;

  logic unused_ok;
  assign unused_ok = ^{pc_i, ghist_i};

  always_comb begin
    idx_o = pc_i[IDX_W+1:2];
    for (int i = 0; i < int'(USE_LEN); i++) begin
      idx_o[i % int'(IDX_W)] = idx_o[i % int'(IDX_W)] ^ ghist_i[i];
    end
  end

endmodule

// File: rtl/sc_ctr_table.sv
module sc_ctr_table #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CTR_W = 6,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic signed [CTR_W-1:0] rd_ctr_o,
  input  logic                    wr_en_i,
  input  logic                    wr_up_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  output logic signed [CTR_W-1:0] wr_ctr_o
);

  localparam logic signed [CTR_W-1:0] CTR_MAX = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic signed [CTR_W-1:0] CTR_MIN = {1'b1, {(CTR_W-1){1'b0}}};

  logic signed [CTR_W-1:0] mem_q [DEPTH];
  logic signed [CTR_W-1:0] cur, nxt;

  assign rd_ctr_o = mem_q[rd_idx_i];
  assign cur      = mem_q[wr_idx_i];
  assign wr_ctr_o = cur;

  always_comb begin
    nxt = cur;
    if (wr_up_i) begin
      if (cur != CTR_MAX) nxt = cur + CTR_W'(1);
    end else begin
      if (cur != CTR_MIN) nxt = cur - CTR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= nxt;
    end
  end

  // R7
  ctr_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && cur == CTR_MAX) |=> mem_q[$past(wr_idx_i)] == CTR_MAX);

  // R7
  ctr_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && cur == CTR_MIN) |=> mem_q[$past(wr_idx_i)] == CTR_MIN);

  // R6
  ctr_step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && cur != CTR_MAX) |=> mem_q[$past(wr_idx_i)] > $past(cur));

  // R6
  ctr_step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && cur != CTR_MIN) |=> mem_q[$past(wr_idx_i)] < $past(cur));

endmodule

// File: rtl/sc_vote.sv
module sc_vote #(
  parameter int unsigned NUM_TABLES = 4,
  parameter int unsigned CTR_W      = 6,
  parameter int unsigned PROV_W     = 3,
  parameter int unsigned SUM_W      = 11,
  parameter int unsigned THRESH     = 20
) (
  input  logic [NUM_TABLES*CTR_W-1:0] ctrs_i,
  input  logic                        dir_i,
  input  logic [PROV_W-1:0]           prov_i,
  output logic [SUM_W-1:0]            mag_o,
  output logic                        final_o,
  output logic                        weak_o
);

  logic [PROV_W-1:0] prov_abs;
  logic [SUM_W-1:0]  seed_mag, acc;
  logic              vote_taken;

  always_comb begin
    prov_abs = prov_i[PROV_W-1] ? (~prov_i + PROV_W'(1)) : prov_i;
    seed_mag = {{(SUM_W-PROV_W-1){1'b0}}, prov_abs, 1'b1};
    acc      = dir_i ? seed_mag : (~seed_mag + SUM_W'(1));
    for (int t = 0; t < int'(NUM_TABLES); t++) begin
      // 2c+1 with sign extension
      acc = acc + {{(SUM_W-CTR_W-1){ctrs_i[t*CTR_W+CTR_W-1]}},
                   ctrs_i[t*CTR_W +: CTR_W], 1'b1};
    end
    vote_taken = ~acc[SUM_W-1];
    mag_o      = acc[SUM_W-1] ? (~acc + SUM_W'(1)) : acc;
    weak_o     = (mag_o <= SUM_W'(THRESH));
    final_o    = (vote_taken != dir_i && !weak_o) ? vote_taken : dir_i;
  end

endmodule

// File: rtl/sc_corrector.sv
module sc_corrector #(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned GHIST_W     = 64,
  parameter int unsigned NUM_TABLES  = 4,
  parameter int unsigned TABLE_DEPTH = 256,
  parameter int unsigned CTR_W       = 6,
  parameter int unsigned PROV_W      = 3,
  parameter int unsigned THRESH      = 20,
  parameter logic [NUM_TABLES*sc_pkg::HLEN_W-1:0] HIST_LENS = {8'd32, 8'd16, 8'd8, 8'd0},
  localparam int unsigned IDX_W = $clog2(TABLE_DEPTH),
  localparam int unsigned SUM_W = sc_pkg::sum_width(CTR_W, PROV_W, NUM_TABLES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pred_valid_i,
  input  logic [PC_W-1:0]    pred_pc_i,
  input  logic [GHIST_W-1:0] pred_ghist_i,
  input  logic               pred_dir_i,
  input  logic [PROV_W-1:0]  pred_ctr_i,
  output logic               pred_valid_o,
  output logic               pred_taken_o,
  output logic [SUM_W-1:0]   pred_mag_o,
  input  logic               upd_valid_i,
  input  logic [PC_W-1:0]    upd_pc_i,
  input  logic [GHIST_W-1:0] upd_ghist_i,
  input  logic               upd_dir_i,
  input  logic [PROV_W-1:0]  upd_ctr_i,
  input  logic               upd_taken_i
);

  import sc_pkg::*;

  logic [IDX_W-1:0]            pred_idx [NUM_TABLES];
  logic [IDX_W-1:0]            upd_idx  [NUM_TABLES];
  logic [NUM_TABLES*CTR_W-1:0] pred_ctrs, upd_ctrs;

  logic [SUM_W-1:0] pred_mag, upd_mag;
  logic             pred_final, upd_final;
  logic             pred_weak_unused, upd_weak;
  train_act_e       train_act;
  logic             tbl_we, tbl_up;

  for (genvar t = 0; t < int'(NUM_TABLES); t++) begin : g_tbl
    localparam int unsigned LEN_T = int'(HIST_LENS[t*HLEN_W +: HLEN_W]);

    sc_index_hash #(
      .PC_W(PC_W), .GHIST_W(GHIST_W), .IDX_W(IDX_W), .HLEN(LEN_T)
    ) u_hash_pred (
      .pc_i(pred_pc_i), .ghist_i(pred_ghist_i), .idx_o(pred_idx[t])
    );

    sc_index_hash #(
      .PC_W(PC_W), .GHIST_W(GHIST_W), .IDX_W(IDX_W), .HLEN(LEN_T)
    ) u_hash_upd (
      .pc_i(upd_pc_i), .ghist_i(upd_ghist_i), .idx_o(upd_idx[t])
    );

    sc_ctr_table #(
      .DEPTH(TABLE_DEPTH), .CTR_W(CTR_W)
    ) u_table (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_idx_i (pred_idx[t]),
      .rd_ctr_o (pred_ctrs[t*CTR_W +: CTR_W]),
      .wr_en_i  (tbl_we),
      .wr_up_i  (tbl_up),
      .wr_idx_i (upd_idx[t]),
      .wr_ctr_o (upd_ctrs[t*CTR_W +: CTR_W])
    );
  end

  sc_vote #(
    .NUM_TABLES(NUM_TABLES), .CTR_W(CTR_W), .PROV_W(PROV_W),
    .SUM_W(SUM_W), .THRESH(THRESH)
  ) u_vote_pred (
    .ctrs_i(pred_ctrs), .dir_i(pred_dir_i), .prov_i(pred_ctr_i),
    .mag_o(pred_mag), .final_o(pred_final), .weak_o(pred_weak_unused)
  );

  sc_vote #(
    .NUM_TABLES(NUM_TABLES), .CTR_W(CTR_W), .PROV_W(PROV_W),
    .SUM_W(SUM_W), .THRESH(THRESH)
  ) u_vote_upd (
    .ctrs_i(upd_ctrs), .dir_i(upd_dir_i), .prov_i(upd_ctr_i),
    .mag_o(upd_mag), .final_o(upd_final), .weak_o(upd_weak)
  );

  logic unused_upd_mag;
  assign unused_upd_mag = ^upd_mag;

  // train on a wrong or low-confidence corrected prediction
  always_comb begin
    train_act = TRAIN_NONE;
    if (upd_valid_i && (upd_final != upd_taken_i || upd_weak)) begin
      train_act = upd_taken_i ? TRAIN_UP : TRAIN_DOWN;
    end
  end

  assign tbl_we = (train_act != TRAIN_NONE);
  assign tbl_up = (train_act == TRAIN_UP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_o <= 1'b0;
      pred_taken_o <= 1'b0;
      pred_mag_o   <= '0;
    end else begin
      pred_valid_o <= pred_valid_i;
      if (pred_valid_i) begin
        pred_taken_o <= pred_final;
        pred_mag_o   <= pred_mag;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> pred_valid_o);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> !pred_valid_o);

  // R5
  override_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> (pred_taken_o == $past(pred_dir_i)) || (pred_mag_o > SUM_W'(THRESH)));

  // R8
  train_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> !tbl_we);

endmodule

// File: tb/sim_sc_corrector.sv
module sim_sc_corrector;

  localparam int NT    = 4;
  localparam int DEPTH = 256;
  localparam int CW    = 3;   // narrow counters so both limits are reachable
  localparam int PW    = 3;
  localparam int TH    = 20;
  localparam int SW    = ((CW > PW) ? CW : PW) + $clog2(NT + 2) + 2;
  localparam int CMAX  = (1 << (CW - 1)) - 1;
  localparam int CMIN  = -(1 << (CW - 1));
  localparam int HL [NT] = '{0, 8, 16, 32};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pred_valid_i = 1'b0;
  logic [31:0]   pred_pc_i = '0;
  logic [63:0]   pred_ghist_i = '0;
  logic          pred_dir_i = 1'b0;
  logic [PW-1:0] pred_ctr_i = '0;
  logic          pred_valid_o, pred_taken_o;
  logic [SW-1:0] pred_mag_o;
  logic          upd_valid_i = 1'b0;
  logic [31:0]   upd_pc_i = '0;
  logic [63:0]   upd_ghist_i = '0;
  logic          upd_dir_i = 1'b0;
  logic [PW-1:0] upd_ctr_i = '0;
  logic          upd_taken_i = 1'b0;

  always #2 clk = ~clk;

  sc_corrector #(.CTR_W(CW), .PROV_W(PW), .THRESH(TH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i), .pred_ghist_i(pred_ghist_i),
    .pred_dir_i(pred_dir_i), .pred_ctr_i(pred_ctr_i),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o), .pred_mag_o(pred_mag_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_ghist_i(upd_ghist_i),
    .upd_dir_i(upd_dir_i), .upd_ctr_i(upd_ctr_i), .upd_taken_i(upd_taken_i)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  taken;
    int    mag;
    string req;
  } exp_t;
  exp_t sb_q [$];

  int mdl [NT][DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R3 model: address bits [9:2] xor byte-wise fold of the masked history
  function automatic int addr_of(input logic [31:0] pc, input logic [63:0] gh, input int len);
    logic [63:0] m;
    int h;
    m = (len >= 64) ? gh : (gh & ((64'd1 << len) - 64'd1));
    h = int'(pc[9:2]);
    for (int k = 0; k < 8; k++) h = h ^ int'((m >> (8 * k)) & 64'hFF);
    return h;
  endfunction

  // R4/R5 model
  task automatic vote(input logic [31:0] pc, input logic [63:0] gh, input logic dir,
                      input logic signed [PW-1:0] pctr, output int mag, output logic fin);
    int p, s;
    p = int'(pctr);
    if (p < 0) p = -p;
    s = dir ? (2 * p + 1) : -(2 * p + 1);
    for (int t = 0; t < NT; t++) s += 2 * mdl[t][addr_of(pc, gh, HL[t])] + 1;
    mag = (s < 0) ? -s : s;
    fin = dir;
    if (((s >= 0) != dir) && mag > TH) fin = (s >= 0);
  endtask

  task automatic do_pred(input logic [31:0] pc, input logic [63:0] gh, input logic dir,
                         input logic signed [PW-1:0] pctr, input string req);
    exp_t e;
    int m;
    logic f;
    vote(pc, gh, dir, pctr, m, f);
    e.taken = f; e.mag = m; e.req = req;
    pred_pc_i = pc; pred_ghist_i = gh; pred_dir_i = dir; pred_ctr_i = pctr;
    pred_valid_i = 1'b1;
    @(posedge clk);
    sb_q.push_back(e);
    #1 pred_valid_i = 1'b0;
  endtask

  // R6/R7 model
  task automatic do_upd(input logic [31:0] pc, input logic [63:0] gh, input logic dir,
                        input logic signed [PW-1:0] pctr, input logic taken);
    int m;
    logic f;
    vote(pc, gh, dir, pctr, m, f);
    if (f != taken || m <= TH) begin
      for (int t = 0; t < NT; t++) begin
        int a;
        a = addr_of(pc, gh, HL[t]);
        if (taken) mdl[t][a] = (mdl[t][a] < CMAX) ? mdl[t][a] + 1 : CMAX;
        else       mdl[t][a] = (mdl[t][a] > CMIN) ? mdl[t][a] - 1 : CMIN;
      end
    end
    upd_pc_i = pc; upd_ghist_i = gh; upd_dir_i = dir; upd_ctr_i = pctr; upd_taken_i = taken;
    upd_valid_i = 1'b1;
    @(posedge clk);
    #1 upd_valid_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pred_valid_o) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "valid with no request", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(pred_taken_o == e.taken, e.req, "direction", int'(pred_taken_o), int'(e.taken));
          check(int'(pred_mag_o) == e.mag, e.req, "magnitude", int'(pred_mag_o), e.mag);
        end
      end else if (sb_q.size() != 0) begin
        check(1'b0, "R2", "result missing one cycle after request", 0, 1);
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] PC_A = 32'h0000_0040;
  localparam logic [31:0] PC_B = 32'h0000_0200;

  initial begin
    for (int t = 0; t < NT; t++) for (int i = 0; i < DEPTH; i++) mdl[t][i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(pred_valid_o == 1'b0, "R1", "valid after reset", int'(pred_valid_o), 0);
    @(posedge clk); #1;

    // R1 R4: zero counters give seed + 4
    do_pred(32'h0, 64'h0, 1'b1, 3'sd2, "R1 R4 fresh taken");
    do_pred(32'h0, 64'h0, 1'b0, 3'sd0, "R5 weak disagreement kept");
    do_pred(32'h4, 64'h0, 1'b0, -3'sd4, "R4 negative seed");

    // R6 R7: opposing seed keeps the vote weak while counters climb to the limit
    for (int k = 0; k < 6; k++) do_upd(PC_A, 64'h0, 1'b0, -3'sd4, 1'b1);
    do_pred(PC_A, 64'h0, 1'b0, 3'sd0, "R7 upper limit override");
    do_pred(PC_A, 64'h0, 1'b0, -3'sd4, "R5 magnitude 19 kept");
    do_pred(PC_A, 64'h0, 1'b0, -3'sd3, "R5 magnitude 21 flips");
    do_pred(PC_A, 64'h0, 1'b1, 3'sd3, "R4 agreeing vote");

    // R3: history and address bits outside each table's slice
    do_pred(PC_A, 64'hFFFF_FFFF_0000_0000, 1'b0, 3'sd0, "R3 high history ignored");
    do_pred(PC_A | 32'h0000_0C03, 64'h0, 1'b0, 3'sd0, "R3 outer pc bits ignored");
    do_pred(PC_A, 64'h0010_0000, 1'b0, 3'sd0, "R3 bit 20 moves one table");
    do_pred(PC_A, 64'h0000_0400, 1'b0, 3'sd0, "R3 bit 10 moves two tables");
    do_pred(PC_A, 64'h0000_0008, 1'b0, 3'sd0, "R3 bit 3 moves three tables");
    do_pred(PC_A | 32'h4, 64'h0, 1'b0, 3'sd0, "R3 pc bit 2 moves all");

    // R6: confident and correct -> no change
    do_upd(PC_A, 64'h0, 1'b0, 3'sd0, 1'b1);
    do_pred(PC_A, 64'h0, 1'b0, 3'sd0, "R6 no training when confident");

    // R8: fields without valid, and repeated lookups, change nothing
    upd_pc_i = PC_A; upd_ghist_i = 64'h0; upd_dir_i = 1'b0; upd_ctr_i = 3'sd0; upd_taken_i = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) do_pred(PC_A, 64'h0, 1'b0, 3'sd0, "R8 no hidden training");

    // R6: confident but wrong -> step down
    do_upd(PC_A, 64'h0, 1'b0, 3'sd0, 1'b0);
    do_pred(PC_A, 64'h0, 1'b0, 3'sd0, "R6 train on wrong override");

    // R7: lower limit
    for (int k = 0; k < 7; k++) do_upd(PC_B, 64'h0, 1'b1, -3'sd4, 1'b0);
    do_pred(PC_B, 64'h0, 1'b1, 3'sd0, "R7 lower limit override");
    do_pred(PC_B, 64'h0, 1'b1, -3'sd4, "R5 negative vote weak");

    // mixed traffic, back-to-back
    for (int k = 0; k < 600; k++) begin
      logic [31:0] pc;
      logic [63:0] gh;
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 7));
      pc = {22'h0, sel[1:0], 6'h0} | 32'h0000_0100;
      gh = {32'h0, 16'($urandom_range(0, 3)) << 14, 8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))};
      if ($urandom_range(0, 1) == 1)
        do_pred(pc, gh, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), "R4 R5 R6 mixed");
      else
        do_upd(pc, gh, 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
               1'($urandom_range(0, 1)));
    end

    repeat (3) @(posedge clk);
    #1;
    check(sb_q.size() == 0, "R2", "results outstanding", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule